// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block produces the access address for one port of a synchronous memory. At every rising clock edge it takes one of four actions. It can take an address from the external bus, step its internal counter up by one, keep the present address, or return to a saved repeat address. The chosen address appears on the output register one clock later and stays there until the next edge.

The counter has three active-low strobes: load, advance and repeat. A separate repeat register captures each address loaded from the external bus, so a burst can be replayed from its start in a single cycle. The block does not see any chip or byte enables, so its counting never depends on them.

When strobes are asserted together, repeat wins, then load, then advance. With no strobe asserted, the counter holds its value. The address width is a parameter, and the counter wraps from all ones to zero. A synchronous active-high reset clears both the counter and the repeat register.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `cur_addr` becomes zero one edge later, and so does the repeat register. Asserting `rpt_n` right after reset therefore yields address zero.
- R2: When `load_n` is 0 and `rpt_n` is 1 at an edge, `cur_addr` equals the `ext_addr` sampled at that edge from the following cycle on.
- R3: When `rpt_n` and `load_n` are 1 and `adv_n` is 0 at an edge, `cur_addr` becomes its previous value plus one.
- R4: When all three strobes are 1 at an edge, `cur_addr` keeps its previous value, and `ext_addr` has no effect on it.
- R5: Advancing from the all-ones address gives zero.
- R6: When `rpt_n` is 0 at an edge, `cur_addr` becomes the repeat register's value as it stood before that edge. This happens whatever the levels of `load_n` and `adv_n`.
- R7: Every edge with `load_n` at 0 writes `ext_addr` into the repeat register. This also happens when `rpt_n` is 0 at the same edge, and in that case the counter takes the older saved value.
- R8: When `load_n` and `adv_n` are both 0 and `rpt_n` is 1, the load wins and no increment occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | AW | External address bus |
| load_n | input | 1 | Load strobe, active low |
| adv_n | input | 1 | Advance strobe, active low |
| rpt_n | input | 1 | Repeat strobe, active low |
| cur_addr | output | AW | Address used for the current access |

## Verification
The properties take for granted that all three strobes hold known levels at every edge after reset. They also assume the external bus carries a known value whenever a load is requested. Without these, priority and capture cannot be judged. The stimulus changes every input only at the falling edge, and always to a defined 0 or 1 pattern. Both the directed sequences and the randomized stretch respect these assumptions, so the bench exercises every combination of strobes without leaving the assumed input space.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_ADV  = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_RPT  = 2'd3
    } act_e;

    typedef struct packed {
        logic rpt;
        logic load;
        logic adv;
    } strobe_t;

    function automatic strobe_t to_active_high(logic load_n, logic adv_n, logic rpt_n);
        strobe_t s;
        s.rpt  = ~rpt_n;
        s.load = ~load_n;
        s.adv  = ~adv_n;
        return s;
    endfunction

    function automatic act_e pick_action(strobe_t s);
        if (s.rpt)       return ACT_RPT;
        else if (s.load) return ACT_LOAD;
        else if (s.adv)  return ACT_ADV;
        else             return ACT_HOLD;
    endfunction

endpackage

// File: rtl/burst_ctrl_decode.sv
module burst_ctrl_decode
    import burst_addr_pkg::*;
(
    input  logic load_n,
    input  logic adv_n,
    input  logic rpt_n,
    output act_e act,
    output logic capture
);
    strobe_t strb;

    always_comb begin
        strb    = to_active_high(load_n, adv_n, rpt_n);
        act     = pick_action(strb);
        capture = strb.load;
    end
endmodule

// File: rtl/burst_rpt_reg.sv
module burst_rpt_reg #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] saved
);
    always_ff @(posedge clk) begin
        if (rst)
            saved <= '0;
        else if (capture)
            saved <= ext_addr;
    end
endmodule

// File: rtl/burst_cnt_core.sv
module burst_cnt_core
    import burst_addr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  act_e          act,
    input  logic [AW-1:0] ext_addr,
    input  logic [AW-1:0] saved,
    output logic [AW-1:0] cnt
);
    localparam logic [AW-1:0] STEP = AW'(1);

    logic [AW-1:0] cnt_nxt;

    always_comb begin
        unique case (act)
            ACT_RPT:  cnt_nxt = saved;
            ACT_LOAD: cnt_nxt = ext_addr;
            ACT_ADV:  cnt_nxt = cnt + STEP;
            default:  cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ext_addr,
    input  logic          load_n,
    input  logic          adv_n,
    input  logic          rpt_n,
    output logic [AW-1:0] cur_addr
);
    act_e          act;
    logic          capture;
    logic [AW-1:0] rpt_q;

    burst_ctrl_decode u_dec (
        .load_n  (load_n),
        .adv_n   (adv_n),
        .rpt_n   (rpt_n),
        .act     (act),
        .capture (capture)
    );

    burst_rpt_reg #(.AW(AW)) u_rpt (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .ext_addr (ext_addr),
        .saved    (rpt_q)
    );

    burst_cnt_core #(.AW(AW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .ext_addr (ext_addr),
        .saved    (rpt_q),
        .cnt      (cur_addr)
    );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] ext_addr,
    input logic          load_n,
    input logic          adv_n,
    input logic          rpt_n,
    input logic [AW-1:0] cur_addr,
    input logic [AW-1:0] rpt_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cur_addr == '0 && rpt_q == '0));

    assert_load_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (!load_n && rpt_n) |=> cur_addr == $past(ext_addr));

    assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (load_n && !adv_n && rpt_n) |=> cur_addr == AW'($past(cur_addr) + 1'b1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (load_n && adv_n && rpt_n) |=> $stable(cur_addr));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (load_n && !adv_n && rpt_n && (&cur_addr)) |=> cur_addr == '0);

    assert_repeat_R6: assert property (@(posedge clk) disable iff (rst)
        !rpt_n |=> cur_addr == $past(rpt_q));

    assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> rpt_q == $past(ext_addr));

    assert_keep_saved_R7: assert property (@(posedge clk) disable iff (rst)
        load_n |=> $stable(rpt_q));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .load_n   (load_n),
    .adv_n    (adv_n),
    .rpt_n    (rpt_n),
    .cur_addr (cur_addr),
    .rpt_q    (rpt_q)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
    localparam int AW = 8;
    localparam int MAXV = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          load_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          rpt_n = 1'b1;
    logic [AW-1:0] cur_addr;

    int compared = 0;
    int mismatched = 0;
    int m_cur = 0;
    int m_rpt = 0;

    always #2 clk = ~clk;

    burst_addr_gen #(.AW(AW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .ext_addr (ext_addr),
        .load_n   (load_n),
        .adv_n    (adv_n),
        .rpt_n    (rpt_n),
        .cur_addr (cur_addr)
    );

    task automatic check(input string req);
        compared++;
        if (int'(cur_addr) !== m_cur) begin
            mismatched++;
            $display("FAIL %s: cur_addr actual=%0d expected=%0d", req, cur_addr, m_cur);
        end
    endtask

    // Drive strobes after a falling edge, let one rising edge pass,
    // update the behavioural model, then compare at the next falling edge.
    task automatic step(input logic ld, input logic ad, input logic rp,
                        input int ea, input string req);
        int old_rpt;
        load_n   = ld;
        adv_n    = ad;
        rpt_n    = rp;
        ext_addr = AW'(ea);
        @(posedge clk);
        old_rpt = m_rpt;
        if (!ld) m_rpt = ea % MAXV;
        if (!rp)      m_cur = old_rpt;
        else if (!ld) m_cur = ea % MAXV;
        else if (!ad) m_cur = (m_cur + 1) % MAXV;
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #(4 * 150000);
        mismatched++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        m_cur = 0;
        m_rpt = 0;
        check("R1");
        rst = 1'b0;
        step(1, 1, 0, 77, "R1");          // repeat right after reset gives zero
        step(0, 1, 1, 10, "R2");
        step(1, 0, 1, 200, "R3");
        step(1, 0, 1, 5, "R3");
        step(1, 1, 1, 99, "R4");          // bus ignored
        step(1, 1, 1, 250, "R4");
        step(1, 1, 0, 3, "R6");           // back to 10
        step(1, 0, 0, 3, "R6");           // repeat beats advance
        step(0, 0, 1, 40, "R8");          // load beats advance
        step(0, 1, 0, 60, "R7");          // counter gets 40, saved becomes 60
        step(1, 1, 0, 0, "R7");           // now 60
        step(0, 1, 1, 254, "R2");
        step(1, 0, 1, 0, "R5");           // 255
        step(1, 0, 1, 0, "R5");           // wraps to 0
        step(1, 1, 0, 0, "R6");           // back to 254
        for (int i = 0; i < 400; i++) begin
            logic ld, ad, rp;
            string tag;
            ld = 1'($urandom_range(0, 1));
            ad = 1'($urandom_range(0, 1));
            rp = 1'($urandom_range(0, 3) != 0);
            if (!rp)      tag = "R6";
            else if (!ld) tag = ad ? "R2" : "R8";
            else if (!ad) tag = "R3";
            else          tag = "R4";
            step(ld, ad, rp, int'($urandom_range(0, MAXV - 1)), tag);
        end
        rst = 1'b1;
        @(posedge clk);
        m_cur = 0;
        m_rpt = 0;
        @(negedge clk);
        check("R1");
        rst = 1'b0;
        step(1, 1, 0, 9, "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule